// File: doc/BRIEF.md
# Serial Transceiver Channel Loopback Steering

This block is the loopback selector and steering logic of one channel in a byte-wide serial link transceiver. A 2-bit select picks one of three behaviours. In normal operation the host's transmit byte and flags go to the encoder, and the external receive bit feeds clock recovery. In serial loopback the serializer's output bit is sent back into clock recovery instead of the external receive bit, so host bytes pass through encode, serialize, loop, deserialize and decode. In parallel loopback the receiver's decoded byte is fed to the encoder in place of the host byte.

In parallel loopback the command/data flag to the encoder is built from the receiver's link status. If the link is lost or resynchronizing, an idle comma control character (byte 0xBC with the flag set) is sent. Otherwise the flag copies the receiver's special-character bit. This means control characters loop back as control characters, and errored or out-of-band receptions loop back as ordinary data. The word-sync enable is held low in parallel loopback. The special-character select stays under host control. The serial line output always carries the serializer bit. The encoder, clock recovery and elastic buffer are outside this block and are reached through ports.

Top module: `lpbk_steer_top`

## Requirements
- R1: While `rst` is high, the select register holds normal mode, whatever `lb_sel` is. The encoder outputs then equal the host inputs, and `cdr_in` equals `line_rx_bit`.
- R2: In normal mode (select 2'b00), `enc_byte`, `enc_cd`, `enc_wsync` and `enc_kchar` equal `host_tx_byte`, `host_cd`, `host_wsync` and `host_kchar`, and `cdr_in` equals `line_rx_bit`.
- R3: In serial loopback (select 2'b10), `cdr_in` equals `ser_tx_bit`, and the encoder outputs still equal the host inputs.
- R4: `line_tx` equals `ser_tx_bit` under every select value.
- R5: In parallel loopback (select 2'b01), `enc_byte` equals `rx_byte` as sampled at the previous clock edge, provided the link status sampled at that edge was not 3'b001 or 3'b010.
- R6: In parallel loopback, `enc_wsync` is 0.
- R7: In parallel loopback, `enc_kchar` equals `host_kchar`.
- R8: In parallel loopback, if the link status sampled at the previous edge was 3'b001 (loss of signal) or 3'b010 (resync), then `enc_cd` is 1 and `enc_byte` is 8'hBC.
- R9: In parallel loopback, for any other link status (000 normal, 011 disparity error, 100 out-of-band, 101 underflow, 110 overflow), `enc_cd` equals `rx_kstat` as sampled at the previous edge. With `rx_kstat` = 0, the byte is therefore looped back as data.
- R10: Link status 3'b111 (reserved) is handled the same way as 3'b000.
- R11: `lb_sel` is registered, so a new value takes effect after the next rising clock edge. Select 2'b11 behaves exactly like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst | input | 1 | Synchronous reset, active high |
| lb_sel | input | 2 | Loopback select: 00 normal, 01 parallel, 10 serial, 11 as normal |
| host_tx_byte | input | 8 | Host transmit byte |
| host_cd | input | 1 | Host command/data flag (1 = control character) |
| host_wsync | input | 1 | Host word-sync enable |
| host_kchar | input | 1 | Host special-character select |
| rx_byte | input | 8 | Receiver decoded byte |
| rx_kstat | input | 1 | Receiver special-character status |
| rx_link | input | 3 | Receiver link status code |
| ser_tx_bit | input | 1 | Serializer output bit |
| line_rx_bit | input | 1 | External receive line bit |
| enc_byte | output | 8 | Byte to the encoder |
| enc_cd | output | 1 | Command/data flag to the encoder |
| enc_wsync | output | 1 | Word-sync enable to the transmitter |
| enc_kchar | output | 1 | Special-character select to the encoder |
| cdr_in | output | 1 | Bit to clock/data recovery |
| line_tx | output | 1 | External transmit line bit |

## Verification
The select register and the two loop registers set everything that leaves the block. A wrong select state shows up at once, in the first sampling window after the edge: `enc_byte` or `cdr_in` comes from the wrong source. A wrong idle decision or a wrong flag in the loop registers shows up one edge after the offending link status, as a byte that is not 0xBC or a flag that does not match. The stimulus table visits every link status code and every select value. Each entry is chosen so that host and receive values differ, which makes any wrong source selection visible.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  localparam int BYTE_W = 8;
  localparam int LINK_W = 3;
  localparam int SEL_W  = 2;
  localparam logic [BYTE_W-1:0] IDLE_COMMA = 8'hBC;

  typedef enum logic [SEL_W-1:0] {
    LB_NORM = 2'b00,
    LB_PAR  = 2'b01,
    LB_SER  = 2'b10,
    LB_RSVD = 2'b11
  } lb_mode_e;

  typedef enum logic [LINK_W-1:0] {
    LS_OK     = 3'b000,
    LS_LOS    = 3'b001,
    LS_RESYNC = 3'b010,
    LS_DISP   = 3'b011,
    LS_OOB    = 3'b100,
    LS_UNDER  = 3'b101,
    LS_OVER   = 3'b110,
    LS_RSVD   = 3'b111
  } link_st_e;

  // Link down or resynchronizing: the loop must emit idle commas.
  function automatic logic link_wants_idle(input logic [LINK_W-1:0] st);
    return (st == LS_LOS) || (st == LS_RESYNC);
  endfunction

  function automatic logic loop_flag(input logic [LINK_W-1:0] st, input logic kst);
    return link_wants_idle(st) ? 1'b1 : kst;
  endfunction

  function automatic logic [BYTE_W-1:0] loop_byte(input logic [LINK_W-1:0] st,
                                                  input logic [BYTE_W-1:0] rxb);
    return link_wants_idle(st) ? IDLE_COMMA : rxb;
  endfunction
endpackage

// File: rtl/lpbk_mode_reg.sv
module lpbk_mode_reg
  import lpbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_in,
  output logic             mode_par,
  output logic             mode_ser
);
  lb_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LB_NORM;
    else     mode_q <= lb_mode_e'(sel_in);
  end

  // Reserved select decodes to neither loop, i.e. as normal.
  assign mode_par = (mode_q == LB_PAR);
  assign mode_ser = (mode_q == LB_SER);

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_par, mode_ser}));  // R11
  AST_SEL_TAKES_PAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_in) == LB_PAR) |-> mode_par);  // R11
  AST_RSVD_IS_NORM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_in) == LB_RSVD) |-> (!mode_par && !mode_ser));  // R11
endmodule

// File: rtl/lpbk_par_src.sv
module lpbk_par_src
  import lpbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_kstat,
  input  logic [LINK_W-1:0] rx_link,
  output logic [BYTE_W-1:0] lp_byte,
  output logic              lp_cd
);
  logic idle_evt;
  assign idle_evt = link_wants_idle(rx_link);

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_byte <= '0;
      lp_cd   <= 1'b0;
    end else begin
      lp_byte <= loop_byte(rx_link, rx_byte);
      lp_cd   <= loop_flag(rx_link, rx_kstat);
    end
  end

  AST_IDLE_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idle_evt)) |-> (lp_cd && lp_byte == IDLE_COMMA));  // R8
  AST_FLAG_FOLLOWS_K: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(idle_evt)) |-> (lp_cd == $past(rx_kstat)));  // R9
  AST_BYTE_FOLLOWS_RX: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(idle_evt)) |-> (lp_byte == $past(rx_byte)));  // R5
endmodule

// File: rtl/lpbk_serial_route.sv
module lpbk_serial_route (
  input  logic mode_ser,
  input  logic ser_tx_bit,
  input  logic line_rx_bit,
  output logic cdr_in,
  output logic line_tx
);
  assign cdr_in  = mode_ser ? ser_tx_bit : line_rx_bit;
  assign line_tx = ser_tx_bit;
endmodule

// File: rtl/lpbk_steer_top.sv
module lpbk_steer_top
  import lpbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  lb_sel,
  input  logic [BYTE_W-1:0] host_tx_byte,
  input  logic              host_cd,
  input  logic              host_wsync,
  input  logic              host_kchar,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_kstat,
  input  logic [LINK_W-1:0] rx_link,
  input  logic              ser_tx_bit,
  input  logic              line_rx_bit,
  output logic [BYTE_W-1:0] enc_byte,
  output logic              enc_cd,
  output logic              enc_wsync,
  output logic              enc_kchar,
  output logic              cdr_in,
  output logic              line_tx
);
  logic              mode_par, mode_ser;
  logic [BYTE_W-1:0] lp_byte;
  logic              lp_cd;

  lpbk_mode_reg u_mode (
    .clk(clk), .rst(rst), .sel_in(lb_sel),
    .mode_par(mode_par), .mode_ser(mode_ser)
  );

  lpbk_par_src u_par (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_kstat(rx_kstat),
    .rx_link(rx_link), .lp_byte(lp_byte), .lp_cd(lp_cd)
  );

  lpbk_serial_route u_ser (
    .mode_ser(mode_ser), .ser_tx_bit(ser_tx_bit), .line_rx_bit(line_rx_bit),
    .cdr_in(cdr_in), .line_tx(line_tx)
  );

  assign enc_byte  = mode_par ? lp_byte : host_tx_byte;
  assign enc_cd    = mode_par ? lp_cd   : host_cd;
  assign enc_wsync = mode_par ? 1'b0    : host_wsync;
  assign enc_kchar = host_kchar;

  AST_PAR_NO_WSYNC: assert property (@(posedge clk) disable iff (rst)
    mode_par |-> !enc_wsync);  // R6
  AST_SER_FEEDS_CDR: assert property (@(posedge clk) disable iff (rst)
    mode_ser |-> (cdr_in == ser_tx_bit));  // R3
  AST_HOST_PASS: assert property (@(posedge clk) disable iff (rst)
    !mode_par |-> (enc_byte == host_tx_byte && enc_cd == host_cd));  // R2
  AST_LINE_EXT_RX: assert property (@(posedge clk) disable iff (rst)
    !mode_ser |-> (cdr_in == line_rx_bit));  // R2
endmodule

// File: tb/tb_lpbk_steer_top.sv
`timescale 1ns/1ps
module tb_lpbk_steer_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lb_sel = 2'b00;
  logic [7:0] host_tx_byte = 8'h00;
  logic       host_cd = 1'b0, host_wsync = 1'b0, host_kchar = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_kstat = 1'b0;
  logic [2:0] rx_link = 3'b000;
  logic       ser_tx_bit = 1'b0, line_rx_bit = 1'b0;
  logic [7:0] enc_byte;
  logic       enc_cd, enc_wsync, enc_kchar, cdr_in, line_tx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpbk_steer_top dut (
    .clk(clk), .rst(rst), .lb_sel(lb_sel), .host_tx_byte(host_tx_byte),
    .host_cd(host_cd), .host_wsync(host_wsync), .host_kchar(host_kchar),
    .rx_byte(rx_byte), .rx_kstat(rx_kstat), .rx_link(rx_link),
    .ser_tx_bit(ser_tx_bit), .line_rx_bit(line_rx_bit),
    .enc_byte(enc_byte), .enc_cd(enc_cd), .enc_wsync(enc_wsync),
    .enc_kchar(enc_kchar), .cdr_in(cdr_in), .line_tx(line_tx)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] sel;
    logic [2:0] link;
    logic       kst;
    logic [7:0] rxb;
    logic [7:0] hb;
    logic       hcd, hws, hk, ser, lrx;
    logic [7:0] eb;
    logic       ecd, ews, ek, ecdr, eltx;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    // req sel    link    k     rx     host  cd ws k  ser lrx | eb    cd ws k  cdr ltx
    '{4'd2,  2'b00, 3'b000, 1'b0, 8'h33, 8'h5A, 1,1,0, 1,0, 8'h5A, 1,1,0, 0,1}, // R2 R4
    '{4'd11, 2'b11, 3'b000, 1'b0, 8'h33, 8'hA5, 0,0,1, 0,1, 8'hA5, 0,0,1, 1,0}, // R11 reserved select
    '{4'd3,  2'b10, 3'b000, 1'b0, 8'h33, 8'h3C, 1,1,0, 1,0, 8'h3C, 1,1,0, 1,1}, // R3
    '{4'd4,  2'b10, 3'b000, 1'b0, 8'h33, 8'h3C, 1,1,0, 0,1, 8'h3C, 1,1,0, 0,0}, // R3 R4
    '{4'd5,  2'b01, 3'b000, 1'b0, 8'h47, 8'h11, 1,1,1, 1,0, 8'h47, 0,0,1, 0,1}, // R5 R6 R7
    '{4'd9,  2'b01, 3'b000, 1'b1, 8'h7C, 8'h11, 0,1,0, 0,1, 8'h7C, 1,0,0, 1,0}, // R9 control
    '{4'd8,  2'b01, 3'b001, 1'b0, 8'h12, 8'h11, 0,1,0, 1,0, 8'hBC, 1,0,0, 0,1}, // R8 LOS
    '{4'd8,  2'b01, 3'b010, 1'b0, 8'h99, 8'h11, 0,1,1, 1,0, 8'hBC, 1,0,1, 0,1}, // R8 resync
    '{4'd9,  2'b01, 3'b011, 1'b0, 8'h21, 8'h11, 1,1,0, 1,0, 8'h21, 0,0,0, 0,1}, // R9 disparity
    '{4'd9,  2'b01, 3'b100, 1'b0, 8'h22, 8'h11, 1,1,0, 1,0, 8'h22, 0,0,0, 0,1}, // R9 out-of-band
    '{4'd9,  2'b01, 3'b101, 1'b0, 8'h23, 8'h11, 1,1,0, 1,0, 8'h23, 0,0,0, 0,1}, // R9 underflow
    '{4'd9,  2'b01, 3'b110, 1'b1, 8'h24, 8'h11, 0,1,0, 1,0, 8'h24, 1,0,0, 0,1}, // R9 overflow
    '{4'd10, 2'b01, 3'b111, 1'b1, 8'hFE, 8'h11, 0,1,0, 1,0, 8'hFE, 1,0,0, 0,1}, // R10
    '{4'd8,  2'b01, 3'b001, 1'b1, 8'h00, 8'h11, 0,1,0, 1,0, 8'hBC, 1,0,0, 0,1}, // R8 k ignored
    '{4'd2,  2'b00, 3'b001, 1'b1, 8'h66, 8'h77, 0,1,1, 1,0, 8'h77, 0,1,1, 0,1}  // R2 back to normal
  };

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] outs();
    return {enc_byte, enc_cd, enc_wsync, enc_kchar, cdr_in, line_tx};
  endfunction

  initial begin
    // R1: reset holds normal mode even with parallel select requested
    lb_sel = 2'b01; host_tx_byte = 8'hC3; host_cd = 1; host_wsync = 1; host_kchar = 0;
    rx_byte = 8'h0F; line_rx_bit = 1; ser_tx_bit = 0;
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), {8'hC3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
    rst = 1'b0;
    // R11: select not yet applied before the edge
    #1 check("R11 pre-edge", outs(), {8'hC3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
    @(negedge clk);
    check("R11 post-edge", outs(), {8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      lb_sel = TBL[i].sel; rx_link = TBL[i].link; rx_kstat = TBL[i].kst;
      rx_byte = TBL[i].rxb; host_tx_byte = TBL[i].hb; host_cd = TBL[i].hcd;
      host_wsync = TBL[i].hws; host_kchar = TBL[i].hk;
      ser_tx_bit = TBL[i].ser; line_rx_bit = TBL[i].lrx;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), outs(),
            {TBL[i].eb, TBL[i].ecd, TBL[i].ews, TBL[i].ek, TBL[i].ecdr, TBL[i].eltx});
    end

    // R7: host kchar changes pass straight through in parallel loopback
    lb_sel = 2'b01; rx_link = 3'b000; @(negedge clk);
    host_kchar = 1'b1; #1 check("R7 kchar live", {12'd0, enc_kchar}, 13'd1);
    // R4: serial bit toggling reaches line in parallel mode
    ser_tx_bit = 1'b1; #1 check("R4 line_tx", {12'd0, line_tx}, 13'd1);
    // R1: reset returns to normal from parallel
    rst = 1'b1; host_tx_byte = 8'h44; @(negedge clk);
    check("R1 reset from parallel", {5'd0, enc_byte}, {5'd0, 8'h44});
    rst = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule